// File: doc/BRIEF.md
# Audio Transmit Sample Packer

This block sits on the write side of an audio transmit path. A processor writes 32-bit words to a transmit data register. The block formats each word into 20-bit left-justified sample slots and stores the result in an on-chip FIFO. The FIFO depth is a power-of-two parameter between 8 and 2048.

A separate configuration write selects the sample width and asks for compact packing. In compact packing, one bus word carries two 16-bit halves and produces two FIFO entries. The block keeps four status flags current after every data write: empty, half-empty, full and underrun.

A downstream stage can read any stored entry through a peek port. That stage reports underruns back through a strobe. Draining the FIFO belongs to that downstream stage and is not part of this block.

Top module: `audtx_packer`

## Requirements
- R1: The 2-bit `cfgSize` field selects the sample width: 0 is 16-bit (shift left 4), 1 is 18-bit (shift left 2), 2 is 20-bit (no shift) and 3 is 12-bit (shift left 8). In normal mode each accepted write stores one entry, `(dataWord << shift) & 0xFFFFF`, at index equal to the level before the write.
- R2: In compact mode each accepted write stores two entries. Bits 15:0 go to index `level` and bits 31:16 go to index `level+1`. Each half is shifted left by 8 for size 3 and by 4 for size 0, then kept to 20 bits.
- R3: A compact request made together with size 1 or 2 is ignored, and writes behave as normal single-entry writes.
- R4: A normal write is accepted only while level < DEPTH. Otherwise it is dropped and leaves the level and the stored entries unchanged.
- R5: A compact write is accepted only while level + 2 < DEPTH. Otherwise it is dropped, so compact writes alone never raise the level above DEPTH-1.
- R6: After any data write whose resulting level is nonzero, `txEmpty` and `txUnderrun` are 0.
- R7: `txHalfEmpty` is 1 after reset and goes to 0 after the data write that brings the level to at least DEPTH/2.
- R8: `txFull` goes to 1 after the data write that brings the level to DEPTH, and stays 0 while the level is below DEPTH.
- R9: After reset the level is 0, `txEmpty` and `txHalfEmpty` are 1, `txFull` and `txUnderrun` are 0, and the configuration is 16-bit normal mode.
- R10: A pulse on `underrunSet` sets `txUnderrun`. A data write in the same cycle that leaves a nonzero level overrides it and keeps the flag clear.
- R11: A configuration write takes effect for data writes in later cycles. A data write in the same cycle as a configuration write uses the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Strobe that loads the configuration |
| cfgSize | input | 2 | Sample-width code |
| cfgCompactReq | input | 1 | Request for two-halves-per-word packing |
| dataWrite | input | 1 | Single-cycle data write strobe |
| dataWord | input | 32 | Data written by the processor |
| underrunSet | input | 1 | Underrun report from the drain side |
| peekIdx | input | $clog2(DEPTH) | FIFO entry index to read |
| peekData | output | 20 | Stored slot at `peekIdx` |
| fifoLevel | output | $clog2(DEPTH)+1 | Number of stored entries |
| txEmpty | output | 1 | Empty flag |
| txHalfEmpty | output | 1 | Half-empty flag |
| txFull | output | 1 | Full flag |
| txUnderrun | output | 1 | Underrun flag |

## Verification
The assertions assume that strobes are single-cycle pulses driven away from the clock edge. They also assume that nothing outside the block lowers the level, because no drain is present. With those assumptions, level growth is monotonic and the full flag can be tied to a level of exactly DEPTH.

The stimulus stays within those assumptions. It resets before every formatting vector and before every directed scenario. It then drives the level upward only through normal and compact writes, and it pushes past DEPTH on purpose to exercise the drop rules.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  // Left-shift that places a sample at the top of a 20-bit slot
  typedef enum logic [3:0] {
    SH0 = 4'd0,
    SH2 = 4'd2,
    SH4 = 4'd4,
    SH8 = 4'd8
  } shiftSel_e;

  // Sample width codes as written in the configuration field
  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ18 = 2'd1,
    SZ20 = 2'd2,
    SZ12 = 2'd3
  } sizeSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      pushNormal;
    logic      pushPair;
    shiftSel_e shift;
  } pushStrobe_t;

  localparam int unsigned SLOT_W = 20;

endpackage

// File: rtl/audtx_ctrl.sv
module audtx_ctrl
  import audtx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgSize,
  input  logic             cfgCompactReq,
  input  logic             dataWrite,
  input  logic             underrunSet,
  output pushStrobe_t      strobe,
  output logic [LVL_W-1:0] level,
  output logic             txEmpty,
  output logic             txHalfEmpty,
  output logic             txFull,
  output logic             txUnderrun
);

  localparam logic [LVL_W:0] DEPTH_X = (LVL_W + 1)'(DEPTH);
  localparam logic [LVL_W:0] HALF_X  = (LVL_W + 1)'(DEPTH / 2);

  sizeSel_e       sizeQ;
  logic           compactQ;
  shiftSel_e      shiftSel;
  logic           roomOne;
  logic           roomTwo;
  logic           pushNormal;
  logic           pushPair;
  logic [LVL_W:0] levelX;
  logic [LVL_W:0] nextLevel;

  // Configuration register; compact only survives for 16-bit or 12-bit widths
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeQ    <= SZ16;
      compactQ <= 1'b0;
    end else if (cfgWrite) begin
      sizeQ    <= sizeSel_e'(cfgSize);
      compactQ <= cfgCompactReq &&
                  ((sizeSel_e'(cfgSize) == SZ16) || (sizeSel_e'(cfgSize) == SZ12));
    end
  end

  always_comb begin
    unique case (sizeQ)
      SZ16:    shiftSel = SH4;
      SZ18:    shiftSel = SH2;
      SZ20:    shiftSel = SH0;
      default: shiftSel = SH8;
    endcase
  end

  assign levelX     = {1'b0, level};
  assign roomOne    = levelX < DEPTH_X;
  assign roomTwo    = (levelX + 2) < DEPTH_X;
  assign pushNormal = dataWrite && !compactQ && roomOne;
  assign pushPair   = dataWrite && compactQ && roomTwo;
  assign nextLevel  = levelX + (pushNormal ? 1 : 0) + (pushPair ? 2 : 0);

  assign strobe = '{pushNormal: pushNormal, pushPair: pushPair, shift: shiftSel};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level       <= '0;
      txEmpty     <= 1'b1;
      txHalfEmpty <= 1'b1;
      txFull      <= 1'b0;
      txUnderrun  <= 1'b0;
    end else begin
      level <= nextLevel[LVL_W-1:0];
      if (dataWrite && (nextLevel != 0)) begin
        txEmpty    <= 1'b0;
        txUnderrun <= 1'b0;
      end else if (underrunSet) begin
        txUnderrun <= 1'b1;
      end
      if (dataWrite && (nextLevel >= HALF_X)) txHalfEmpty <= 1'b0;
      if (dataWrite && (nextLevel >= DEPTH_X)) txFull <= 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, level} <= DEPTH_X); // R4

  AST_NORMAL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && !compactQ && ({1'b0, level} == DEPTH_X)) |=> $stable(level)); // R4

  AST_PAIR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && compactQ && (({1'b0, level} + 2) >= DEPTH_X)) |=> $stable(level)); // R5

  AST_COMPACT_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    compactQ |-> ((sizeQ == SZ16) || (sizeQ == SZ12))); // R3

  AST_EMPTY_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (level != 0) |-> !txEmpty); // R6

  AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    txFull |-> ({1'b0, level} == DEPTH_X)); // R8

endmodule

// File: rtl/audtx_datapath.sv
module audtx_datapath
  import audtx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pushStrobe_t       strobe,
  input  logic [LVL_W-1:0]  base,
  input  logic [31:0]       dataWord,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [SLOT_W-1:0] peekData
);

  logic [SLOT_W-1:0] slotMem [DEPTH];
  logic [31:0]       shiftedWord;
  logic [31:0]       shiftedLo;
  logic [31:0]       shiftedHi;
  logic [IDX_W-1:0]  idxA;
  logic [IDX_W-1:0]  idxB;

  assign shiftedWord = dataWord << strobe.shift;
  assign shiftedLo   = {16'h0, dataWord[15:0]} << strobe.shift;
  assign shiftedHi   = {16'h0, dataWord[31:16]} << strobe.shift;
  assign idxA        = base[IDX_W-1:0];
  assign idxB        = idxA + 1'b1;

  always_ff @(posedge clk) begin
    if (strobe.pushNormal) begin
      slotMem[idxA] <= shiftedWord[SLOT_W-1:0];
    end else if (strobe.pushPair) begin
      slotMem[idxA] <= shiftedLo[SLOT_W-1:0];
      slotMem[idxB] <= shiftedHi[SLOT_W-1:0];
    end
  end

  assign peekData = slotMem[peekIdx];

  AST_PAIR_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushPair |-> (({1'b0, base} + 2) < (LVL_W + 1)'(DEPTH))); // R5

  AST_PAIR_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushPair |-> ((strobe.shift == SH4) || (strobe.shift == SH8))); // R2

  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pushNormal, strobe.pushPair})); // R3

endmodule

// File: rtl/audtx_packer.sv
module audtx_packer
  import audtx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgSize,
  input  logic              cfgCompactReq,
  input  logic              dataWrite,
  input  logic [31:0]       dataWord,
  input  logic              underrunSet,
  input  logic [IDX_W-1:0]  peekIdx,
  output logic [SLOT_W-1:0] peekData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              txEmpty,
  output logic              txHalfEmpty,
  output logic              txFull,
  output logic              txUnderrun
);

  pushStrobe_t strobe;

  audtx_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrite     (cfgWrite),
    .cfgSize      (cfgSize),
    .cfgCompactReq(cfgCompactReq),
    .dataWrite    (dataWrite),
    .underrunSet  (underrunSet),
    .strobe       (strobe),
    .level        (fifoLevel),
    .txEmpty      (txEmpty),
    .txHalfEmpty  (txHalfEmpty),
    .txFull       (txFull),
    .txUnderrun   (txUnderrun)
  );

  audtx_datapath #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IDX_W(IDX_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .base    (fifoLevel),
    .dataWord(dataWord),
    .peekIdx (peekIdx),
    .peekData(peekData)
  );

endmodule

// File: tb/tb_audtx_packer.sv
`timescale 1ns/1ps
module tb_audtx_packer;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [1:0]  cfgSize = 2'd0;
  logic        cfgCompactReq = 1'b0;
  logic        dataWrite = 1'b0;
  logic [31:0] dataWord = '0;
  logic        underrunSet = 1'b0;
  logic [2:0]  peekIdx = '0;
  logic [19:0] peekData;
  logic [3:0]  fifoLevel;
  logic        txEmpty, txHalfEmpty, txFull, txUnderrun;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  audtx_packer #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSize(cfgSize),
    .cfgCompactReq(cfgCompactReq), .dataWrite(dataWrite), .dataWord(dataWord),
    .underrunSet(underrunSet), .peekIdx(peekIdx), .peekData(peekData),
    .fifoLevel(fifoLevel), .txEmpty(txEmpty), .txHalfEmpty(txHalfEmpty),
    .txFull(txFull), .txUnderrun(txUnderrun)
  );

  // {size code, written word, expected slot}
  localparam logic [53:0] VEC [6] = '{
    {2'd0, 32'h0001_2345, 20'h23450},
    {2'd1, 32'h0003_FFFF, 20'hFFFFC},
    {2'd2, 32'h0ABC_DE12, 20'hCDE12},
    {2'd3, 32'h0000_0FFF, 20'hFFF00},
    {2'd3, 32'hFFFF_F123, 20'h12300},
    {2'd0, 32'hFFFF_8765, 20'h87650}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doCfg(input logic [1:0] sz, input logic comp);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSize = sz; cfgCompactReq = comp;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic doData(input logic [31:0] w);
    @(negedge clk);
    dataWrite = 1'b1; dataWord = w;
    @(negedge clk);
    dataWrite = 1'b0;
  endtask

  task automatic peekChk(input string tag, input int idx, input logic [19:0] exp);
    peekIdx = 3'(idx);
    #0.1;
    chk(tag, {12'h0, peekData}, {12'h0, exp});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R9 reset state
    chk("R9 level", 32'(fifoLevel), 0);
    chk("R9 flags", {28'h0, txEmpty, txHalfEmpty, txFull, txUnderrun}, 32'hC);
    doData(32'h0000_0123);
    peekChk("R9 default 16-bit", 0, 20'h01230);

    // R1 formatting table
    for (int i = 0; i < 6; i++) begin
      doReset();
      doCfg(VEC[i][53:52], 1'b0);
      doData(VEC[i][51:20]);
      chk("R1 level", 32'(fifoLevel), 1);
      peekChk("R1 slot", 0, VEC[i][19:0]);
    end

    // R2 compact 16-bit and 12-bit
    doReset();
    doCfg(2'd0, 1'b1);
    doData(32'hBEEF_1234);
    chk("R2 level", 32'(fifoLevel), 2);
    peekChk("R2 low first", 0, 20'h12340);
    peekChk("R2 high second", 1, 20'hBEEF0);
    doReset();
    doCfg(2'd3, 1'b1);
    doData(32'h0ABC_0DEF);
    peekChk("R2 low 12-bit", 0, 20'hDEF00);
    peekChk("R2 high 12-bit", 1, 20'hABC00);

    // R3 compact request ignored for 18-bit and 20-bit
    doReset();
    doCfg(2'd1, 1'b1);
    doData(32'h0001_2345);
    chk("R3 level 18", 32'(fifoLevel), 1);
    peekChk("R3 slot 18", 0, 20'h48D14);
    doReset();
    doCfg(2'd2, 1'b1);
    doData(32'h1234_5678);
    chk("R3 level 20", 32'(fifoLevel), 1);
    peekChk("R3 slot 20", 0, 20'h45678);

    // R6 R7 R8 R4 normal fill to full and past it
    doReset();
    doData(32'h1);
    chk("R6 empty clears", 32'(txEmpty), 0);
    chk("R6 underrun clear", 32'(txUnderrun), 0);
    doData(32'h2);
    doData(32'h3);
    chk("R7 half-empty at 3", 32'(txHalfEmpty), 1);
    doData(32'h4);
    chk("R7 half-empty at 4", 32'(txHalfEmpty), 0);
    doData(32'h5); doData(32'h6); doData(32'h7);
    chk("R8 not full at 7", 32'(txFull), 0);
    doData(32'h8);
    chk("R8 full at 8", 32'(txFull), 1);
    chk("R8 level 8", 32'(fifoLevel), 8);
    doData(32'hF);
    chk("R4 drop level", 32'(fifoLevel), 8);
    peekChk("R4 entry 7 kept", 7, 20'h00080);
    peekChk("R4 entry 0 kept", 0, 20'h00010);

    // R5 compact admission from odd level
    doReset();
    doData(32'h1);
    doCfg(2'd0, 1'b1);
    doData(32'h0002_0003);
    doData(32'h0004_0005);
    doData(32'h0006_0007);
    chk("R5 level 7", 32'(fifoLevel), 7);
    doData(32'h0009_0008);
    chk("R5 drop at 7", 32'(fifoLevel), 7);
    chk("R5 not full", 32'(txFull), 0);
    peekChk("R5 entry 6", 6, 20'h00060);
    // R5 compact from zero stops at 6
    doReset();
    doCfg(2'd0, 1'b1);
    doData(32'h1); doData(32'h1); doData(32'h1);
    chk("R5 level 6", 32'(fifoLevel), 6);
    doData(32'h1);
    chk("R5 drop at 6", 32'(fifoLevel), 6);

    // R10 underrun report and override
    doReset();
    @(negedge clk); underrunSet = 1'b1;
    @(negedge clk); underrunSet = 1'b0;
    chk("R10 underrun set", 32'(txUnderrun), 1);
    doData(32'h1);
    chk("R10 push clears", 32'(txUnderrun), 0);
    @(negedge clk); underrunSet = 1'b1; dataWrite = 1'b1; dataWord = 32'h2;
    @(negedge clk); underrunSet = 1'b0; dataWrite = 1'b0;
    chk("R10 push wins", 32'(txUnderrun), 0);

    // R11 same-cycle configuration uses old setting
    doReset();
    doCfg(2'd3, 1'b0);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSize = 2'd0; cfgCompactReq = 1'b0;
    dataWrite = 1'b1; dataWord = 32'h0000_0ABC;
    @(negedge clk);
    cfgWrite = 1'b0; dataWrite = 1'b0;
    peekChk("R11 old config", 0, 20'hABC00);
    doData(32'h0000_0ABC);
    peekChk("R11 new config", 1, 20'h0ABC0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule